// File: doc/BRIEF.md
# Bus Abort Generator

This block sits beside the processor's bus port and judges every access in the cycle it is presented. It decides whether the processor takes an abort, and whether the access is suppressed before it reaches its target. Instruction fetches that fault raise a prefetch abort. Data accesses that fault raise a data abort. Each fault kind follows its own rule, and one kind, a forbidden write to a protected peripheral register, is suppressed without any abort.

The decision outputs are combinational, so they can be used in the same cycle as the access. On the clock edge that ends an aborting access, the block records three things in status registers: the cause, the faulting address and the access type. The recorded values stay until the next abort or a reset.

Top module: `bus_abort_unit`

## Requirements
- R1: A valid access with `regionSel` = 2'd0 (external bus) and `extDefined` low raises an abort and drives `accCancel` high in the same cycle.
- R2: An access is misaligned when `accSize` = 2'd1 (half-word) and address bit 0 is set, or when `accSize` = 2'd2 (word) and address bits 1:0 are non-zero. A misaligned access raises an abort in every region. Byte accesses (`accSize` = 2'd0) are never misaligned.
- R3: A misaligned access is not cancelled, whether it is a read or a write, unless R1 or R5 also applies to it.
- R4: An aligned access with `regionSel` = 2'd1 (internal memory), 2'd2 (internal peripheral) or 2'd3 (treated as internal) never raises an abort, whatever `extDefined` is.
- R5: A write with `regionSel` = 2'd2, `protReg` high and `privMode` low is cancelled. When aligned, it raises no abort.
- R6: An aborting access with `accInstr` high raises `prefetchAbort` only. One with `accInstr` low raises `dataAbort` only.
- R7: After an abort, `stsCause` holds 2'd1 for misalignment or 2'd2 for an undefined external address, starting from the next clock edge.
- R8: After an abort, `stsAddr` holds the faulting address. `stsType` holds bit 0 = 1 for a prefetch abort and bit 1 = 1 for a write.
- R9: Each abort overwrites all three status registers. Cycles without an abort leave them unchanged.
- R10: Reset clears `stsCause`, `stsAddr` and `stsType` to zero.
- R11: An access that is both misaligned and to an undefined external address records cause 2'd1. It is still cancelled.
- R12: With `accValid` low, no abort or cancel is raised and the status registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accAddr | input | ADDR_W | Access address |
| accSize | input | 2 | 0 byte, 1 half-word, 2 word |
| accWrite | input | 1 | 1 write, 0 read |
| accInstr | input | 1 | 1 instruction fetch, 0 data access |
| regionSel | input | 2 | 0 external bus, 1 internal memory, 2 internal peripheral, 3 internal |
| extDefined | input | 1 | The external address decodes to a defined device |
| protReg | input | 1 | Target is a mode-protected peripheral register |
| privMode | input | 1 | Processor is in a mode allowed to write protected registers |
| dataAbort | output | 1 | Data abort for the current access |
| prefetchAbort | output | 1 | Prefetch abort for the current access |
| accCancel | output | 1 | Suppress the current access |
| stsCause | output | 2 | Cause of the last abort |
| stsAddr | output | ADDR_W | Address of the last abort |
| stsType | output | 2 | Type of the last abort: bit 0 prefetch, bit 1 write |

## Verification
The assertions assume that the inputs are stable and defined while `accValid` is high, and that `accSize` never carries the reserved value 3. They also assume that `extDefined` matters only for the external region. The stimulus draws sizes only from 0 to 2, and inputs change only on the falling clock edge. Directed accesses cover each cause, the combined misaligned-and-undefined case and the silent protection fault. Randomly drawn accesses then mix regions, alignments and modes, with idle cycles between them.

// File: rtl/bus_abort_pkg.sv
package bus_abort_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_MISALIGN = 2'd1,
    CAUSE_UNDEFEXT = 2'd2
  } abortCause_e;

  localparam logic [1:0] REGION_EXT    = 2'd0;
  localparam logic [1:0] REGION_IMEM   = 2'd1;
  localparam logic [1:0] REGION_PERIPH = 2'd2;

  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [1:0] SIZE_HALF = 2'd1;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef struct packed {
    logic        capture;
    abortCause_e cause;
    logic        prefetch;
  } abortStrobes_t;
endpackage

// File: rtl/abort_ctrl.sv
module abort_ctrl
  import bus_abort_pkg::*;
(
  input  logic          accValid,
  input  logic [1:0]    addrLow,
  input  logic [1:0]    accSize,
  input  logic          accWrite,
  input  logic          accInstr,
  input  logic [1:0]    regionSel,
  input  logic          extDefined,
  input  logic          protReg,
  input  logic          privMode,
  output logic          dataAbort,
  output logic          prefetchAbort,
  output logic          accCancel,
  output abortStrobes_t strobes
);
  logic misaligned;
  logic undefExt;
  logic protFault;
  logic anyAbort;

  always_comb begin
    unique case (accSize)
      SIZE_HALF: misaligned = addrLow[0];
      SIZE_WORD: misaligned = |addrLow;
      default:   misaligned = 1'b0;
    endcase
  end

  assign undefExt  = (regionSel == REGION_EXT) && !extDefined;
  assign protFault = accWrite && protReg && !privMode && (regionSel == REGION_PERIPH);
  assign anyAbort  = accValid && (misaligned || undefExt);

  assign dataAbort     = anyAbort && !accInstr;
  assign prefetchAbort = anyAbort && accInstr;
  assign accCancel     = accValid && (undefExt || protFault);

  always_comb begin
    strobes.capture  = anyAbort;
    strobes.prefetch = accInstr;
    if (misaligned)    strobes.cause = CAUSE_MISALIGN;
    else if (undefExt) strobes.cause = CAUSE_UNDEFEXT;
    else               strobes.cause = CAUSE_NONE;
  end
endmodule

// File: rtl/abort_regs.sv
module abort_regs
  import bus_abort_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  abortStrobes_t     strobes,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  output logic [1:0]        stsCause,
  output logic [ADDR_W-1:0] stsAddr,
  output logic [1:0]        stsType
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsCause <= '0;
      stsAddr  <= '0;
      stsType  <= '0;
    end else if (strobes.capture) begin
      stsCause <= strobes.cause;
      stsAddr  <= accAddr;
      stsType  <= {accWrite, strobes.prefetch};
    end
  end
endmodule

// File: rtl/bus_abort_unit.sv
module bus_abort_unit
  import bus_abort_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  input  logic              accWrite,
  input  logic              accInstr,
  input  logic [1:0]        regionSel,
  input  logic              extDefined,
  input  logic              protReg,
  input  logic              privMode,
  output logic              dataAbort,
  output logic              prefetchAbort,
  output logic              accCancel,
  output logic [1:0]        stsCause,
  output logic [ADDR_W-1:0] stsAddr,
  output logic [1:0]        stsType
);
  abortStrobes_t strobes;

  abort_ctrl uCtrl (
    .accValid(accValid), .addrLow(accAddr[1:0]), .accSize(accSize),
    .accWrite(accWrite), .accInstr(accInstr), .regionSel(regionSel),
    .extDefined(extDefined), .protReg(protReg), .privMode(privMode),
    .dataAbort(dataAbort), .prefetchAbort(prefetchAbort),
    .accCancel(accCancel), .strobes(strobes)
  );

  abort_regs #(.ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .accAddr(accAddr),
    .accWrite(accWrite), .stsCause(stsCause), .stsAddr(stsAddr),
    .stsType(stsType)
  );
endmodule

// File: rtl/bus_abort_checker.sv
module bus_abort_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic [ADDR_W-1:0] accAddr,
  input logic [1:0]        accSize,
  input logic              accWrite,
  input logic              accInstr,
  input logic [1:0]        regionSel,
  input logic              extDefined,
  input logic              protReg,
  input logic              privMode,
  input logic              dataAbort,
  input logic              prefetchAbort,
  input logic              accCancel,
  input logic [1:0]        stsCause,
  input logic [ADDR_W-1:0] stsAddr,
  input logic [1:0]        stsType
);
  logic misal;
  logic abortAny;
  assign misal    = (accSize == 2'd1 && accAddr[0]) || (accSize == 2'd2 && accAddr[1:0] != 2'd0);
  assign abortAny = dataAbort || prefetchAbort;

  AST_UNDEF_EXT_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && regionSel == 2'd0 && !extDefined) |-> (abortAny && accCancel)); // R1
  AST_MISALIGN_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && misal) |-> abortAny); // R2
  AST_MISALIGN_NO_CANCEL: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && misal && regionSel != 2'd0 && !(accWrite && protReg && !privMode)) |-> !accCancel); // R3
  AST_INTERNAL_NO_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !misal && regionSel != 2'd0) |-> !abortAny); // R4
  AST_PROT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !misal && regionSel == 2'd2 && accWrite && protReg && !privMode) |-> (accCancel && !abortAny)); // R5
  AST_KIND_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    abortAny |-> (prefetchAbort == accInstr && dataAbort == !accInstr)); // R6
  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rstN)
    abortAny |=> (stsCause == 2'd1 || stsCause == 2'd2)); // R7
  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    abortAny |=> (stsAddr == $past(accAddr) && stsType[0] == $past(accInstr))); // R8
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !abortAny |=> ($stable(stsCause) && $stable(stsAddr) && $stable(stsType))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> !(abortAny || accCancel)); // R12
endmodule

bind bus_abort_unit bus_abort_checker #(.ADDR_W(ADDR_W)) uChk (.*);

// File: tb/bus_abort_unit_test.sv
module bus_abort_unit_test;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0;
  logic [AW-1:0] accAddr = '0;
  logic [1:0] accSize = '0;
  logic accWrite = 1'b0, accInstr = 1'b0;
  logic [1:0] regionSel = '0;
  logic extDefined = 1'b1, protReg = 1'b0, privMode = 1'b1;
  logic dataAbort, prefetchAbort, accCancel;
  logic [1:0] stsCause, stsType;
  logic [AW-1:0] stsAddr;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  int mCause = 0;
  int mType = 0;
  logic [AW-1:0] mAddr = '0;

  always #2 clk = ~clk;

  bus_abort_unit #(.ADDR_W(AW)) uut (.*);

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one access at the falling edge, check the decision outputs,
  // then at the next falling edge check the status registers against the model.
  task automatic access(bit v, logic [AW-1:0] a, int sz, bit w, bit ins,
                        int reg_, bit def, bit pr, bit priv, string tag);
    bit mis, undef, prot, ab, cn;
    int cause;
    @(negedge clk);
    accValid = v; accAddr = a; accSize = 2'(sz); accWrite = w; accInstr = ins;
    regionSel = 2'(reg_); extDefined = def; protReg = pr; privMode = priv;
    mis   = (sz == 1 && a[0]) || (sz == 2 && a[1:0] != 0);
    undef = (reg_ == 0) && !def;
    prot  = w && pr && !priv && reg_ == 2;
    ab    = v && (mis || undef);
    cn    = v && (undef || prot);
    cause = mis ? 1 : 2;
    #1;
    chk({tag, " dataAbort"}, dataAbort, ab && !ins);
    chk({tag, " prefetchAbort"}, prefetchAbort, ab && ins);
    chk({tag, " accCancel"}, accCancel, cn);
    if (ab) begin
      mCause = cause; mAddr = a; mType = (w ? 2 : 0) + (ins ? 1 : 0);
    end
    @(negedge clk);
    chk({tag, " stsCause"}, stsCause, mCause);
    chk({tag, " stsAddr"}, stsAddr, mAddr);
    chk({tag, " stsType"}, stsType, mType);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 stsCause", stsCause, 0);
    chk("R10 stsAddr", stsAddr, 0);
    chk("R10 stsType", stsType, 0);
    rstN = 1'b1;
    access(1, 32'h1000_0000, 2, 0, 0, 0, 0, 0, 1, "R1 undef ext read");
    access(1, 32'h1000_0010, 2, 1, 1, 0, 0, 0, 1, "R1 R6 undef ext fetch");
    access(1, 32'h0000_0101, 1, 0, 0, 1, 1, 0, 1, "R2 R3 half misaligned read");
    access(1, 32'h0000_0202, 2, 1, 0, 2, 1, 0, 1, "R2 R3 word misaligned write");
    access(1, 32'h0000_0203, 0, 1, 0, 1, 1, 0, 1, "R2 byte never misaligned");
    access(1, 32'h0000_0300, 2, 0, 0, 1, 0, 0, 1, "R4 internal mem undefined");
    access(1, 32'h0000_0304, 1, 1, 0, 2, 0, 0, 1, "R4 periph undefined");
    access(1, 32'h0000_0400, 2, 1, 0, 2, 1, 1, 0, "R5 protected write silent");
    access(1, 32'h0000_0400, 2, 1, 0, 2, 1, 1, 1, "R5 privileged write allowed");
    access(1, 32'h2000_0003, 2, 1, 0, 0, 0, 0, 1, "R11 misaligned and undefined");
    access(1, 32'h3000_0002, 1, 0, 1, 3, 1, 0, 1, "R6 R7 R8 prefetch misaligned");
    access(1, 32'h4000_0000, 2, 0, 0, 0, 1, 0, 1, "R9 defined ext no change");
    access(0, 32'h5000_0001, 2, 1, 0, 0, 0, 0, 1, "R12 idle");
    for (int i = 0; i < 400; i++) begin
      access($urandom_range(0, 5) != 0, $urandom(), $urandom_range(0, 2),
             $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3),
             $urandom_range(0, 2) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
             "R9 random mix");
    end
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule